// File: doc/BRIEF.md
# Host Cycle Decode Window Matcher

This block tells whether a host IO or memory cycle belongs to the peripheral behind a serial side-channel link. A software-visible register set holds four programmable IO windows, four programmable memory windows, three hardwired legacy port decodes, and one shared enable register with a separate bit for each decode. A catch-all (subtractive) mode can also claim any cycle that matches no decode.

Each cycle is shown to the block as a valid strobe together with a type flag (IO or memory) and a 32-bit address. One clock later the block returns a registered hit flag, a source code and the index of the winning decode. The window size fields hold the length minus one. The range test does not wrap past the top of the address space. The shared enable register can switch off every decode with one write, and the window registers can then be rewritten without false claims.

Top module: `host_win_decoder`

## Requirements
- R1: After reset, the decode-enable register (offset 0x00), the global control register (0x04) and all window registers read zero, and `hit` is low.
- R2: An IO window i (register at 0x40+4*i, base in bits [15:0], length-1 in bits [23:16]) whose enable bit 8+i is set claims an IO cycle when base <= addr[15:0] <= base+size. The result shows on `hit`, `hitSrc`=2, `hitIdx`=i at the first clock edge after the one that samples `cycValid`. While `hit` is low, `hitSrc` and `hitIdx` are zero.
- R3: A window that reaches the top of its address space does not wrap. Addresses just above zero are not claimed by a window that ends at the top.
- R4: A memory window j (base at 0x80+8*j, 32 bits; length-1 at 0x84+8*j, bits [15:0]) whose enable bit 12+j is set claims a memory cycle when base <= addr <= base+size, with `hitSrc`=3 and `hitIdx`=j.
- R5: A window whose enable bit is clear never claims a cycle, whatever its base and size hold.
- R6: Fixed IO decodes: bit 0 claims port 0x80, bit 1 claims ports 0x60 and 0x64 (and not 0x61 to 0x63), bit 2 claims ports 0x2E and 0x2F. They report `hitSrc`=1 and `hitIdx` equal to the bit number, and they never claim memory cycles.
- R7: A fixed decode wins over a generic window. Among overlapping generic windows, the lowest index wins.
- R8: Writing zero to the decode-enable register turns off all decodes at once. Base and size registers keep their values.
- R9: Global control bit 0 enables subtractive decode, and bits [2:1] are a target select. Any cycle that matches no enabled decode is then claimed with `hitSrc`=4 and `hitIdx`=0. A write that sets bit 0 forces the select field to zero.
- R10: Register writes update only the bytes whose `regBe` bit is set. Unimplemented bits read zero.
- R11: Memory windows never claim IO cycles, and IO windows and fixed decodes never claim memory cycles.
- R12: With `cycValid` low, `hit` is low on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrite | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset (bits [1:0] ignored) |
| regBe | input | 4 | Byte enables for the write |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| cycValid | input | 1 | Host cycle present |
| cycIsIo | input | 1 | 1 = IO cycle, 0 = memory cycle |
| cycAddr | input | 32 | Cycle address (IO uses bits [15:0]) |
| hit | output | 1 | Cycle claimed (registered) |
| hitSrc | output | 3 | 0 none, 1 fixed, 2 IO window, 3 memory window, 4 subtractive |
| hitIdx | output | 2 | Index of the winning decode |

## Verification
Each window is probed at its first and last address and one step outside on each side. This separates an off-by-one in the size-minus-one handling from a correct range. Windows placed at the top of the IO and memory spaces are probed just above zero, which exposes a compare that wraps. Overlapping windows, a generic window on port 0x80, and a toggled enable bit show priority and gating. The cycle type is swapped on the same addresses to show that the IO and memory decodes stay separate. Partial byte-enable writes, and a subtractive enable written together with a non-zero select, show the register write rules.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
  localparam int IoAddrW  = 16;
  localparam int IoSizeW  = 8;
  localparam int MemAddrW = 32;
  localparam int MemSizeW = 16;
  localparam int MaxWin   = 8;
  localparam int FixCount = 3;
  localparam int IoEnLsb  = 8;

  localparam logic [5:0] WordIoFirst  = 6'd16;
  localparam logic [5:0] WordMemFirst = 6'd32;

  typedef enum logic [2:0] {
    SRC_NONE  = 3'd0,
    SRC_FIXED = 3'd1,
    SRC_IO    = 3'd2,
    SRC_MMIO  = 3'd3,
    SRC_SUBTR = 3'd4
  } hit_src_e;

  typedef enum logic [2:0] {
    TGT_NONE, TGT_DEC, TGT_GLB, TGT_IO, TGT_MBASE, TGT_MSIZE
  } reg_tgt_e;

  typedef struct packed {
    logic        wr;
    reg_tgt_e    tgt;
    logic [2:0]  idx;
    logic [3:0]  be;
    logic [31:0] wdata;
    logic        look;
  } reg_stb_t;

  function automatic logic [31:0] mergeBytes(input logic [31:0] oldV,
                                             input logic [31:0] newV,
                                             input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++)
      r[8*b +: 8] = be[b] ? newV[8*b +: 8] : oldV[8*b +: 8];
    return r;
  endfunction
endpackage

// File: rtl/win_range_cmp.sv
module win_range_cmp #(
  parameter int AddrW = 16,
  parameter int SizeW = 8
) (
  input  logic [AddrW-1:0] addr,
  input  logic [AddrW-1:0] base,
  input  logic [SizeW-1:0] sizeM1,
  output logic             inRange
);
  localparam int PadW = AddrW - SizeW;

  logic [AddrW-1:0] offs;
  logic [AddrW-1:0] limit;

  // Offset form: the end address base+size is never computed, so no wrap
  assign offs  = addr - base;
  assign limit = {{PadW{1'b0}}, sizeM1};

  always_comb inRange = (addr >= base) && (offs <= limit);
endmodule

// File: rtl/win_dec_ctrl.sv
module win_dec_ctrl
  import win_dec_pkg::*;
#(
  parameter int NumIo   = 4,
  parameter int NumMmio = 4
) (
  input  logic        regWrite,
  input  logic [7:0]  regAddr,
  input  logic [3:0]  regBe,
  input  logic [31:0] regWdata,
  input  logic        cycValid,
  output reg_stb_t    stb
);
  logic [5:0] word;
  logic [5:0] ioOff;
  logic [5:0] memOff;

  assign word   = regAddr[7:2];
  assign ioOff  = word - WordIoFirst;
  assign memOff = word - WordMemFirst;

  always_comb begin
    stb       = '0;
    stb.wr    = regWrite;
    stb.be    = regBe;
    stb.wdata = regWdata;
    stb.look  = cycValid;
    stb.tgt   = TGT_NONE;
    if (word == 6'd0) begin
      stb.tgt = TGT_DEC;
    end else if (word == 6'd1) begin
      stb.tgt = TGT_GLB;
    end else if (word >= WordIoFirst && {26'd0, ioOff} < NumIo) begin
      stb.tgt = TGT_IO;
      stb.idx = ioOff[2:0];
    end else if (word >= WordMemFirst && {27'd0, memOff[5:1]} < NumMmio) begin
      stb.tgt = memOff[0] ? TGT_MSIZE : TGT_MBASE;
      stb.idx = memOff[3:1];
    end
  end
endmodule

// File: rtl/win_dec_dp.sv
module win_dec_dp
  import win_dec_pkg::*;
#(
  parameter int NumIo   = 4,
  parameter int NumMmio = 4,
  parameter int IdxW    = 2
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  reg_stb_t                           stb,
  input  logic                               cycIsIo,
  input  logic [31:0]                        cycAddr,
  output logic [31:0]                        regRdata,
  output logic                               hit,
  output logic [2:0]                         hitSrc,
  output logic [IdxW-1:0]                    hitIdx,
  output logic [FixCount+NumIo+NumMmio-1:0]  winEnMask,
  output logic                               subEnQ,
  output logic [1:0]                         subSelQ
);
  localparam int MemEnLsb = IoEnLsb + NumIo;

  logic [FixCount-1:0] fixEn;
  logic [NumIo-1:0]    ioEn;
  logic [NumMmio-1:0]  memEn;

  logic [IoAddrW-1:0]  ioBase  [NumIo];
  logic [IoSizeW-1:0]  ioSize  [NumIo];
  logic [MemAddrW-1:0] memBase [NumMmio];
  logic [MemSizeW-1:0] memSize [NumMmio];

  logic [31:0] decWord;
  logic [31:0] glbWord;
  logic [31:0] decNext;
  logic [31:0] glbNext;

  always_comb begin
    decWord = '0;
    decWord[FixCount-1:0]         = fixEn;
    decWord[IoEnLsb +: NumIo]     = ioEn;
    decWord[MemEnLsb +: NumMmio]  = memEn;
  end
  assign glbWord = {29'd0, subSelQ, subEnQ};
  assign decNext = mergeBytes(decWord, stb.wdata, stb.be);
  assign glbNext = mergeBytes(glbWord, stb.wdata, stb.be);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fixEn <= '0;
      ioEn  <= '0;
      memEn <= '0;
    end else if (stb.wr && stb.tgt == TGT_DEC) begin
      fixEn <= decNext[FixCount-1:0];
      ioEn  <= decNext[IoEnLsb +: NumIo];
      memEn <= decNext[MemEnLsb +: NumMmio];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      subEnQ  <= 1'b0;
      subSelQ <= 2'd0;
    end else if (stb.wr && stb.tgt == TGT_GLB) begin
      subEnQ  <= glbNext[0];
      subSelQ <= glbNext[0] ? 2'd0 : glbNext[2:1];
    end
  end

  logic [NumIo-1:0]   ioCmp;
  logic [NumMmio-1:0] memCmp;

  for (genvar i = 0; i < NumIo; i++) begin : g_io
    logic [31:0] curWord;
    logic [31:0] nxtWord;
    assign curWord = {8'd0, ioSize[i], ioBase[i]};
    assign nxtWord = mergeBytes(curWord, stb.wdata, stb.be);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ioBase[i] <= '0;
        ioSize[i] <= '0;
      end else if (stb.wr && stb.tgt == TGT_IO && {29'd0, stb.idx} == i) begin
        ioBase[i] <= nxtWord[IoAddrW-1:0];
        ioSize[i] <= nxtWord[IoAddrW +: IoSizeW];
      end
    end

    win_range_cmp #(.AddrW(IoAddrW), .SizeW(IoSizeW)) u_cmp (
      .addr    (cycAddr[IoAddrW-1:0]),
      .base    (ioBase[i]),
      .sizeM1  (ioSize[i]),
      .inRange (ioCmp[i])
    );
  end

  for (genvar j = 0; j < NumMmio; j++) begin : g_mem
    logic [31:0] baseNxt;
    logic [31:0] sizeNxt;
    assign baseNxt = mergeBytes(memBase[j], stb.wdata, stb.be);
    assign sizeNxt = mergeBytes({16'd0, memSize[j]}, stb.wdata, stb.be);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        memBase[j] <= '0;
        memSize[j] <= '0;
      end else if (stb.wr && {29'd0, stb.idx} == j) begin
        if (stb.tgt == TGT_MBASE) memBase[j] <= baseNxt;
        if (stb.tgt == TGT_MSIZE) memSize[j] <= sizeNxt[MemSizeW-1:0];
      end
    end

    win_range_cmp #(.AddrW(MemAddrW), .SizeW(MemSizeW)) u_cmp (
      .addr    (cycAddr),
      .base    (memBase[j]),
      .sizeM1  (memSize[j]),
      .inRange (memCmp[j])
    );
  end

  always_comb begin
    regRdata = '0;
    case (stb.tgt)
      TGT_DEC:   regRdata = decWord;
      TGT_GLB:   regRdata = glbWord;
      TGT_IO:    for (int i = 0; i < NumIo; i++)
                   if ({29'd0, stb.idx} == i) regRdata = {8'd0, ioSize[i], ioBase[i]};
      TGT_MBASE: for (int j = 0; j < NumMmio; j++)
                   if ({29'd0, stb.idx} == j) regRdata = memBase[j];
      TGT_MSIZE: for (int j = 0; j < NumMmio; j++)
                   if ({29'd0, stb.idx} == j) regRdata = {16'd0, memSize[j]};
      default:   regRdata = '0;
    endcase
  end

  logic [IoAddrW-1:0]  port;
  logic [FixCount-1:0] fixHit;
  logic [NumIo-1:0]    ioHit;
  logic [NumMmio-1:0]  memHit;
  hit_src_e            srcNow;
  logic [IdxW-1:0]     idxNow;

  assign port      = cycAddr[IoAddrW-1:0];
  assign fixHit[0] = fixEn[0] && port == 16'h0080;
  assign fixHit[1] = fixEn[1] && (port == 16'h0060 || port == 16'h0064);
  assign fixHit[2] = fixEn[2] && port[15:1] == 15'h0017;
  assign ioHit     = ioEn & ioCmp;
  assign memHit    = memEn & memCmp;

  always_comb begin
    logic fFound;
    logic wFound;
    logic [IdxW-1:0] fIdx;
    logic [IdxW-1:0] wIdx;
    fFound = 1'b0;
    wFound = 1'b0;
    fIdx   = '0;
    wIdx   = '0;
    for (int k = FixCount - 1; k >= 0; k--)
      if (fixHit[k]) begin fFound = 1'b1; fIdx = IdxW'(k); end
    if (cycIsIo) begin
      for (int i = NumIo - 1; i >= 0; i--)
        if (ioHit[i]) begin wFound = 1'b1; wIdx = IdxW'(i); end
    end else begin
      for (int j = NumMmio - 1; j >= 0; j--)
        if (memHit[j]) begin wFound = 1'b1; wIdx = IdxW'(j); end
    end
    srcNow = SRC_NONE;
    idxNow = '0;
    if (cycIsIo && fFound) begin
      srcNow = SRC_FIXED;
      idxNow = fIdx;
    end else if (wFound) begin
      srcNow = cycIsIo ? SRC_IO : SRC_MMIO;
      idxNow = wIdx;
    end else if (subEnQ) begin
      srcNow = SRC_SUBTR;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hit    <= 1'b0;
      hitSrc <= SRC_NONE;
      hitIdx <= '0;
    end else begin
      hit    <= stb.look && srcNow != SRC_NONE;
      hitSrc <= stb.look ? srcNow : SRC_NONE;
      hitIdx <= stb.look ? idxNow : '0;
    end
  end

  assign winEnMask = {memEn, ioEn, fixEn};
endmodule

// File: rtl/host_win_decoder.sv
module host_win_decoder
  import win_dec_pkg::*;
#(
  parameter int NumIo   = 4,
  parameter int NumMmio = 4,
  localparam int WinMax = (NumIo > NumMmio) ? NumIo : NumMmio,
  localparam int IdxW   = (WinMax > 4) ? $clog2(WinMax) : 2
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            regWrite,
  input  logic [7:0]      regAddr,
  input  logic [3:0]      regBe,
  input  logic [31:0]     regWdata,
  output logic [31:0]     regRdata,
  input  logic            cycValid,
  input  logic            cycIsIo,
  input  logic [31:0]     cycAddr,
  output logic            hit,
  output logic [2:0]      hitSrc,
  output logic [IdxW-1:0] hitIdx
);
  reg_stb_t stb;
  logic [FixCount+NumIo+NumMmio-1:0] winEnMask;
  logic       subEnQ;
  logic [1:0] subSelQ;

  win_dec_ctrl #(.NumIo(NumIo), .NumMmio(NumMmio)) u_ctrl (
    .regWrite (regWrite),
    .regAddr  (regAddr),
    .regBe    (regBe),
    .regWdata (regWdata),
    .cycValid (cycValid),
    .stb      (stb)
  );

  win_dec_dp #(.NumIo(NumIo), .NumMmio(NumMmio), .IdxW(IdxW)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cycIsIo   (cycIsIo),
    .cycAddr   (cycAddr),
    .regRdata  (regRdata),
    .hit       (hit),
    .hitSrc    (hitSrc),
    .hitIdx    (hitIdx),
    .winEnMask (winEnMask),
    .subEnQ    (subEnQ),
    .subSelQ   (subSelQ)
  );
endmodule

// File: rtl/host_win_decoder_chk.sv
module host_win_decoder_chk #(
  parameter int MaskW = 11,
  parameter int IdxW  = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic            cycValid,
  input logic            cycIsIo,
  input logic            hit,
  input logic [2:0]      hitSrc,
  input logic [IdxW-1:0] hitIdx,
  input logic [MaskW-1:0] winEnMask,
  input logic            subEnQ,
  input logic [1:0]      subSelQ
);
  AST_HIT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    !cycValid |=> !hit); // R12

  AST_QUIET_WHEN_MISS: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (hitSrc == 3'd0 && hitIdx == '0)); // R2

  AST_ALL_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && winEnMask == '0 && !subEnQ) |=> !hit); // R8

  AST_SUB_SEL_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    subEnQ |-> subSelQ == 2'd0); // R9

  AST_SUB_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !subEnQ) |=> hitSrc != 3'd4); // R9

  AST_MEM_NO_IO_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && !cycIsIo) |=> (hitSrc != 3'd1 && hitSrc != 3'd2)); // R11

  AST_IO_NO_MEM_SRC: assert property (@(posedge clk) disable iff (!rstN)
    (cycValid && cycIsIo) |=> hitSrc != 3'd3); // R11
endmodule

bind host_win_decoder host_win_decoder_chk #(
  .MaskW(win_dec_pkg::FixCount + NumIo + NumMmio), .IdxW(IdxW)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycValid  (cycValid),
  .cycIsIo   (cycIsIo),
  .hit       (hit),
  .hitSrc    (hitSrc),
  .hitIdx    (hitIdx),
  .winEnMask (winEnMask),
  .subEnQ    (subEnQ),
  .subSelQ   (subSelQ)
);

// File: tb/host_win_decoder_test.sv
module host_win_decoder_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrite = 1'b0;
  logic [7:0]  regAddr = 8'd0;
  logic [3:0]  regBe = 4'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        cycValid = 1'b0;
  logic        cycIsIo = 1'b0;
  logic [31:0] cycAddr = 32'd0;
  logic        hit;
  logic [2:0]  hitSrc;
  logic [1:0]  hitIdx;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] MISS = 32'd0;

  always #5 clk = ~clk;

  host_win_decoder uut (
    .clk(clk), .rstN(rstN), .regWrite(regWrite), .regAddr(regAddr),
    .regBe(regBe), .regWdata(regWdata), .regRdata(regRdata),
    .cycValid(cycValid), .cycIsIo(cycIsIo), .cycAddr(cycAddr),
    .hit(hit), .hitSrc(hitSrc), .hitIdx(hitIdx)
  );

  function automatic logic [31:0] enc(input logic [2:0] src, input logic [1:0] idx);
    return {26'd0, 1'b1, src, idx};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic regWr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    regWrite = 1'b1; regAddr = a; regBe = be; regWdata = d;
    @(negedge clk);
    regWrite = 1'b0; regBe = 4'd0;
  endtask

  task automatic regChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(tag, regRdata, exp);
  endtask

  // Drive one cycle at a falling edge; the rising edge captures; sample at the next falling edge
  task automatic lookChk(input string tag, input logic isIo, input logic [31:0] a,
                         input logic [31:0] exp);
    @(negedge clk);
    cycValid = 1'b1; cycIsIo = isIo; cycAddr = a;
    @(negedge clk);
    cycValid = 1'b0;
    chk(tag, {26'd0, hit, hitSrc, hitIdx}, exp);
  endtask

  task automatic testReset();
    regChk("R1 decode enable", 8'h00, 32'd0);
    regChk("R1 global ctl", 8'h04, 32'd0);
    regChk("R1 io win2", 8'h48, 32'd0);
    regChk("R1 mem base1", 8'h88, 32'd0);
    chk("R1 hit low", {31'd0, hit}, 32'd0);
    lookChk("R1 no decode after reset", 1'b1, 32'h80, MISS);
  endtask

  task automatic testIoWindow();
    regWr(8'h44, 4'hF, 32'h000F_0300);
    regWr(8'h00, 4'hF, 32'h0000_0200);
    lookChk("R2 io first", 1'b1, 32'h300, enc(3'd2, 2'd1));
    lookChk("R2 io last", 1'b1, 32'h30F, enc(3'd2, 2'd1));
    lookChk("R2 io above", 1'b1, 32'h310, MISS);
    lookChk("R2 io below", 1'b1, 32'h2FF, MISS);
    @(negedge clk);
    chk("R12 hit drops without valid", {31'd0, hit}, 32'd0);
  endtask

  task automatic testTop();
    regWr(8'h48, 4'hF, 32'h00FF_FFF0);
    regWr(8'h00, 4'hF, 32'h0000_0600);
    lookChk("R3 io top", 1'b1, 32'hFFFF, enc(3'd2, 2'd2));
    lookChk("R3 io no wrap", 1'b1, 32'h0005, MISS);
  endtask

  task automatic testMem();
    regWr(8'h80, 4'hF, 32'hFED0_0000);
    regWr(8'h84, 4'hF, 32'h0000_FFFF);
    regWr(8'h98, 4'hF, 32'hFFFF_FFF0);
    regWr(8'h9C, 4'hF, 32'h0000_FFFF);
    regWr(8'h00, 4'hF, 32'h0000_9600);
    lookChk("R4 mem first", 1'b0, 32'hFED0_0000, enc(3'd3, 2'd0));
    lookChk("R4 mem last", 1'b0, 32'hFED0_FFFF, enc(3'd3, 2'd0));
    lookChk("R4 mem above", 1'b0, 32'hFED1_0000, MISS);
    lookChk("R3 mem top", 1'b0, 32'hFFFF_FFFF, enc(3'd3, 2'd3));
    lookChk("R3 mem no wrap", 1'b0, 32'h0000_0004, MISS);
    lookChk("R11 mem cycle vs io window", 1'b0, 32'h300, MISS);
    lookChk("R11 io cycle vs mem window", 1'b1, 32'hFED0_0000, MISS);
  endtask

  task automatic testPriority();
    regWr(8'h40, 4'hF, 32'h0003_0308);
    regWr(8'h00, 4'hF, 32'h0000_9700);
    lookChk("R7 overlap lowest", 1'b1, 32'h309, enc(3'd2, 2'd0));
    lookChk("R7 overlap end", 1'b1, 32'h30B, enc(3'd2, 2'd0));
    lookChk("R7 past low window", 1'b1, 32'h30C, enc(3'd2, 2'd1));
    regWr(8'h00, 4'hF, 32'h0000_9600);
    lookChk("R5 disabled window ignored", 1'b1, 32'h309, enc(3'd2, 2'd1));
  endtask

  task automatic testFixed();
    regWr(8'h4C, 4'hF, 32'h0000_0080);
    regWr(8'h00, 4'hF, 32'h0000_9E07);
    lookChk("R7 fixed over window", 1'b1, 32'h80, enc(3'd1, 2'd0));
    lookChk("R6 port 60", 1'b1, 32'h60, enc(3'd1, 2'd1));
    lookChk("R6 port 64", 1'b1, 32'h64, enc(3'd1, 2'd1));
    lookChk("R6 port 62", 1'b1, 32'h62, MISS);
    lookChk("R6 port 2E", 1'b1, 32'h2E, enc(3'd1, 2'd2));
    lookChk("R6 port 2F", 1'b1, 32'h2F, enc(3'd1, 2'd2));
    lookChk("R6 port 30", 1'b1, 32'h30, MISS);
    lookChk("R6 memory at 80", 1'b0, 32'h80, MISS);
    regWr(8'h00, 4'hF, 32'h0000_9E00);
    lookChk("R5 fixed off, window takes 80", 1'b1, 32'h80, enc(3'd2, 2'd3));
  endtask

  task automatic testAllOff();
    regWr(8'h00, 4'hF, 32'h0000_0000);
    regChk("R8 enable reads zero", 8'h00, 32'd0);
    lookChk("R8 io off", 1'b1, 32'h300, MISS);
    lookChk("R8 mem off", 1'b0, 32'hFED0_0000, MISS);
    regChk("R8 base kept", 8'h44, 32'h000F_0300);
  endtask

  task automatic testSubtractive();
    regWr(8'h04, 4'h1, 32'h0000_0007);
    regChk("R9 select forced zero", 8'h04, 32'h0000_0001);
    lookChk("R9 mem claimed", 1'b0, 32'h0000_1234, enc(3'd4, 2'd0));
    lookChk("R9 io claimed", 1'b1, 32'h1234, enc(3'd4, 2'd0));
    regWr(8'h00, 4'hF, 32'h0000_0200);
    lookChk("R9 window beats subtractive", 1'b1, 32'h300, enc(3'd2, 2'd1));
    regWr(8'h04, 4'h1, 32'h0000_0006);
    regChk("R9 select kept when off", 8'h04, 32'h0000_0006);
    lookChk("R9 no claim when off", 1'b0, 32'h0000_1234, MISS);
    regWr(8'h04, 4'hF, 32'h0000_0000);
  endtask

  task automatic testByteEnables();
    regWr(8'h40, 4'b0100, 32'hAABB_CCDD);
    regChk("R10 only byte2", 8'h40, 32'h00BB_0308);
    regWr(8'h00, 4'b0010, 32'hFFFF_03FF);
    regChk("R10 enable byte1", 8'h00, 32'h0000_0300);
    regWr(8'h84, 4'b0011, 32'hFFFF_1234);
    regChk("R10 size upper zero", 8'h84, 32'h0000_1234);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testIoWindow();
    testTop();
    testMem();
    testPriority();
    testFixed();
    testAllOff();
    testSubtractive();
    testByteEnables();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule